// File: doc/BRIEF.md
# Cascadable Successive Approximation Register

This block holds the digital state and the bit-by-bit sequencing of a successive-approximation analog-to-digital converter. A conversion is launched by holding the active-low start input low across a rising clock edge. That edge loads the register with its most significant bit low and every other bit high. On each later edge, the comparator decision on the serial input is stored into the bit under trial, and the next lower bit is cleared to become the new trial bit. Once bit 0 has been written, the active-low completion flag falls and the register freezes until the next start.

The parallel outputs drive an external DAC directly. The result is read active-low: a bit that reads low stands for a logic one. A complemented copy of the MSB output is provided for two's-complement use. A serial output repeats the serial input one clock later.

Registers can be chained into a longer one. Clock, serial input and start are shared between the stages. The completion flag of each stage drives the active-low enable of the next less significant stage. While its enable is high, a stage shows its MSB output high and accepts no data. A conversion can also be cut short: the end of conversion is then taken from the edge at which a chosen parallel output first goes low.

Top module: `sar_chain_reg`

## Requirements
- R1: A rising edge with `start_n` low loads the stored register with the MSB low and all other bits high, and sets `done_n` high. With `en_n` low, an 8-bit register then reads 0x7F and a 12-bit register reads 0x7FF.
- R2: After the start edge, while `en_n` is low and `done_n` is high, each rising edge stores `din` into the bit under trial (MSB first) and clears the next lower bit, which becomes the new trial bit. Bits below the trial bit stay high.
- R3: While `done_n` is low and `start_n` is high, the parallel outputs do not change, whatever `din` does.
- R4: Counting the start edge as edge 1, `done_n` falls on edge WIDTH+1, the same edge that writes bit 0, and stays low until the next start.
- R5: `dout` equals the value `din` had at the previous rising edge.
- R6: `q_msb_n` is always the inverse of `q[WIDTH-1]`.
- R7: While `en_n` is high, `q[WIDTH-1]` reads high, no bit is written, and `done_n` stays high. Trials begin on the first edge after `en_n` falls.
- R8: When an 8-bit stage drives the `en_n` of a 4-bit stage through its `done_n`, the pair completes a 12-bit conversion over 13 edges. The lower stage's MSB becomes the trial bit on the same edge that the upper stage completes.
- R9: Bit k first reads low on edge WIDTH-k, counting the start edge as edge 1, so a truncated conversion can end on that edge. Bit 0 is low one edge before `done_n` falls.
- R10: A start edge in the middle of a conversion abandons it and reloads the R1 state.
- R11: Holding `start_n` low across several edges keeps the R1 state on every one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| start_n | input | 1 | Active-low synchronous start of a conversion |
| en_n | input | 1 | Active-low enable; high forces the MSB output high and holds the register |
| din | input | 1 | Serial comparator decision |
| q | output | WIDTH | Parallel register outputs (MSB first), active-low code |
| q_msb_n | output | 1 | Complement of `q[WIDTH-1]` |
| done_n | output | 1 | Active-low conversion complete |
| dout | output | 1 | `din` delayed by one clock |

## Verification
Three instances are driven together: a standalone 8-bit register, a standalone 12-bit register, and an 8-bit stage chained to a 4-bit stage. Each is closed through a behavioural comparator against its own integer input level.

Directed inputs at zero, full scale and mid scale pin every bit to an all-keep or all-drop decision. These cases separate a wrong trial order, or a missing preset of the next bit, from a correct one. Random levels then check every intermediate register image edge by edge, together with the final code. After completion the serial input is randomised to expose any write past bit 0. An aborted conversion and a multi-edge start check that restart takes priority over the trial sequence.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int unsigned SAR_MIN_WIDTH = 2;
   localparam int unsigned SAR_MAX_WIDTH = 64;

   function automatic bit sar_width_ok(input int unsigned w);
      return (w >= SAR_MIN_WIDTH) && (w <= SAR_MAX_WIDTH);
   endfunction
endpackage

// File: rtl/sar_trial_ptr.sv
module sar_trial_ptr #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             start_n,
   input  logic             adv,
   output logic [WIDTH-1:0] ptr,
   output logic             done_n
);
   localparam logic [WIDTH-1:0] PTR_INIT = {1'b1, {(WIDTH-1){1'b0}}};

   always_ff @(posedge clk) begin
      if (!start_n) begin
         ptr    <= PTR_INIT;
         done_n <= 1'b1;
      end else if (adv) begin
         if (ptr[0]) done_n <= 1'b0;
         else        ptr    <= ptr >> 1;
      end
   end
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell #(
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic start_n,
   input  logic adv,
   input  logic sel,
   input  logic preset,
   input  logic din,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!start_n)    q <= RESET_VAL;
      else if (adv) begin
         if (sel)         q <= din;
         else if (preset) q <= 1'b0;
      end
   end
endmodule

// File: rtl/sar_serial_delay.sv
module sar_serial_delay (
   input  logic clk,
   input  logic din,
   output logic dout
);
   always_ff @(posedge clk) dout <= din;
endmodule

// File: rtl/sar_chain_reg.sv
module sar_chain_reg
   import sar_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             start_n,
   input  logic             en_n,
   input  logic             din,
   output logic [WIDTH-1:0] q,
   output logic             q_msb_n,
   output logic             done_n,
   output logic             dout
);
   localparam int unsigned MSB = WIDTH - 1;

   if (!sar_width_ok(WIDTH)) begin : g_bad_width
      $error("sar_chain_reg: WIDTH %0d outside supported range", WIDTH);
   end

   logic [WIDTH-1:0] ptr;
   logic [WIDTH-1:0] bits;
   logic             adv;

   // Trials advance only while enabled and not yet complete.
   assign adv = ~en_n & done_n;

   sar_trial_ptr #(.WIDTH(WIDTH)) u_ptr (
      .clk    (clk),
      .start_n(start_n),
      .adv    (adv),
      .ptr    (ptr),
      .done_n (done_n)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic preset;
      if (i == MSB) begin : g_top
         assign preset = 1'b0;
      end else begin : g_low
         assign preset = ptr[i+1];
      end
      sar_bit_cell #(.RESET_VAL((i == MSB) ? 1'b0 : 1'b1)) u_cell (
         .clk    (clk),
         .start_n(start_n),
         .adv    (adv),
         .sel    (ptr[i]),
         .preset (preset),
         .din    (din),
         .q      (bits[i])
      );
   end

   sar_serial_delay u_dly (
      .clk (clk),
      .din (din),
      .dout(dout)
   );

   assign q       = {bits[MSB] | en_n, bits[MSB-1:0]};
   assign q_msb_n = ~q[MSB];
endmodule

// File: rtl/sar_chain_reg_chk.sv
module sar_chain_reg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             start_n,
   input logic             en_n,
   input logic             din,
   input logic [WIDTH-1:0] q,
   input logic             q_msb_n,
   input logic             done_n,
   input logic             dout
);
   localparam int unsigned MSB = WIDTH - 1;
   logic armed = 1'b0;

   always_ff @(posedge clk) if (!start_n) armed <= 1'b1;

   a_r1_start_loads: assert property (@(posedge clk) disable iff (!armed)
      !start_n |=> (done_n && (q[MSB-1:0] == {(WIDTH-1){1'b1}})));

   a_r3_frozen_when_done: assert property (@(posedge clk) disable iff (!armed)
      (start_n && !done_n && !en_n) |=> (!done_n && $stable(q[MSB-1:0])));

   a_r5_serial_delay: assert property (@(posedge clk) disable iff (!armed)
      1'b1 |=> (dout == $past(din)));

   a_r6_msb_complement: assert property (@(posedge clk) disable iff (!armed)
      q_msb_n != q[MSB]);

   a_r7_enable_forces_msb: assert property (@(posedge clk) disable iff (!armed)
      en_n |-> q[MSB]);

   a_r7_enable_holds: assert property (@(posedge clk) disable iff (!armed)
      (en_n && start_n) |=> ($stable(q[MSB-1:0]) && $stable(done_n)));
endmodule

bind sar_chain_reg sar_chain_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .start_n(start_n),
   .en_n   (en_n),
   .din    (din),
   .q      (q),
   .q_msb_n(q_msb_n),
   .done_n (done_n),
   .dout   (dout)
);

// File: tb/tb_sar_chain_reg.sv
module tb_sar_chain_reg;
   logic clk = 1'b0;
   always #2.5ns clk = ~clk;

   logic start_n = 1'b1;
   logic d8 = 1'b0, d12 = 1'b0, dc = 1'b0;

   logic [7:0]  q8;  logic m8,  c8,  s8;
   logic [11:0] q12; logic m12, c12, s12;
   logic [7:0]  qh;  logic mh,  ch,  sh;
   logic [3:0]  ql;  logic ml,  cl,  sl;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   sar_chain_reg #(.WIDTH(8)) u_s8 (.clk(clk), .start_n(start_n), .en_n(1'b0), .din(d8),
      .q(q8), .q_msb_n(m8), .done_n(c8), .dout(s8));
   sar_chain_reg #(.WIDTH(12)) dut (.clk(clk), .start_n(start_n), .en_n(1'b0), .din(d12),
      .q(q12), .q_msb_n(m12), .done_n(c12), .dout(s12));
   sar_chain_reg #(.WIDTH(8)) u_hi (.clk(clk), .start_n(start_n), .en_n(1'b0), .din(dc),
      .q(qh), .q_msb_n(mh), .done_n(ch), .dout(sh));
   sar_chain_reg #(.WIDTH(4)) u_lo (.clk(clk), .start_n(start_n), .en_n(ch), .din(dc),
      .q(ql), .q_msb_n(ml), .done_n(cl), .dout(sl));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected image after k data edges; active-low code, trial bit low, untried bits high.
   function automatic logic [11:0] exp_q(input logic [11:0] v, input int k, input int w);
      logic [11:0] r = '0;
      for (int pos = 0; pos < w; pos++) begin
         int idx = w - 1 - pos;
         if (idx < k)       r[pos] = ~v[pos];
         else if (idx == k) r[pos] = 1'b0;
         else               r[pos] = 1'b1;
      end
      return r;
   endfunction

   task automatic check_reset(input string tag);
      chk(q8 == 8'h7F && c8, {tag, " s8"}, {23'd0, c8, q8}, {23'd0, 1'b1, 8'h7F});
      chk(q12 == 12'h7FF && c12, {tag, " s12"}, {19'd0, c12, q12}, {19'd0, 1'b1, 12'h7FF});
      chk({qh, ql} == 12'h7FF && ch && cl, {tag, " chain (R7 lower MSB forced)"},
          {18'd0, ch, cl, qh, ql}, {18'd0, 2'b11, 12'h7FF});
      chk(m8 == ~q8[7] && m12 == ~q12[11] && ml == ~ql[3], "R6 msb complement",
          {29'd0, m8, m12, ml}, {29'd0, ~q8[7], ~q12[11], ~ql[3]});
   endtask

   task automatic do_reset(input int n, input string tag);
      start_n = 1'b0;
      d8 = 1'($urandom); d12 = 1'($urandom); dc = 1'($urandom);
      repeat (n) begin
         @(posedge clk); @(negedge clk);
         check_reset(tag);
      end
      start_n = 1'b1;
   endtask

   task automatic run_round(input logic [7:0] v8, input logic [11:0] v12,
                            input logic [11:0] vc, input int abort_at);
      logic p8, p12, pc;
      do_reset(1, "R1 start");
      for (int e = 1; e <= 15; e++) begin
         int k8, k12;
         d8  = (e - 1 < 8)  ? ((v8  >= ~q8)         ? 1'b0 : 1'b1) : 1'($urandom);
         d12 = (e - 1 < 12) ? ((v12 >= ~q12)        ? 1'b0 : 1'b1) : 1'($urandom);
         dc  = (e - 1 < 12) ? ((vc  >= ~{qh, ql})   ? 1'b0 : 1'b1) : 1'($urandom);
         p8 = d8; p12 = d12; pc = dc;
         if (e == abort_at) start_n = 1'b0;
         @(posedge clk); @(negedge clk);
         if (e == abort_at) begin
            check_reset("R10 restart");
            start_n = 1'b1;
            return;
         end
         k8 = (e < 8) ? e : 8;
         k12 = (e < 12) ? e : 12;
         chk(q8 == exp_q({4'd0, v8}, k8, 8)[7:0], (e > 8) ? "R3 s8 hold" : "R2 s8 step",
             {24'd0, q8}, {24'd0, exp_q({4'd0, v8}, k8, 8)[7:0]});
         chk(q12 == exp_q(v12, k12, 12), (e > 12) ? "R3 s12 hold" : "R2 s12 step",
             {20'd0, q12}, {20'd0, exp_q(v12, k12, 12)});
         chk({qh, ql} == exp_q(vc, k12, 12), "R8 chain image", {20'd0, qh, ql},
             {20'd0, exp_q(vc, k12, 12)});
         chk(c8 == (e < 8) && c12 == (e < 12), "R4 done timing", {30'd0, c8, c12},
             {30'd0, 1'(e < 8), 1'(e < 12)});
         chk(ch == (e < 8) && cl == (e < 12), "R8 chain done", {30'd0, ch, cl},
             {30'd0, 1'(e < 8), 1'(e < 12)});
         if (e < 8)
            chk(ql == 4'hF, "R7 lower stage held", {28'd0, ql}, 32'hF);
         chk(s8 == p8 && s12 == p12 && sh == pc && sl == pc, "R5 serial out",
             {28'd0, s8, s12, sh, sl}, {28'd0, p8, p12, pc, pc});
         chk(m8 == ~q8[7] && m12 == ~q12[11] && mh == ~qh[7], "R6 msb complement",
             {29'd0, m8, m12, mh}, {29'd0, ~q8[7], ~q12[11], ~qh[7]});
         if (e == 7)
            chk(q8[0] == 1'b0 && c8, "R9 truncation marker", {30'd0, q8[0], c8}, 32'd1);
         if (e == 15) begin
            chk(~q8 == v8, "R2 s8 final code", {24'd0, ~q8}, {24'd0, v8});
            chk(~q12 == v12, "R2 s12 final code", {20'd0, ~q12}, {20'd0, v12});
            chk(~{qh, ql} == vc, "R8 chain final code", {20'd0, ~{qh, ql}}, {20'd0, vc});
         end
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5ns);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5A2C_0917));
      repeat (3) @(negedge clk);
      run_round(8'd0,   12'd0,    12'd0,    0);
      run_round(8'd255, 12'd4095, 12'd4095, 0);
      run_round(8'd128, 12'd2048, 12'd2048, 0);
      run_round(8'd127, 12'd2047, 12'd255,  0);
      run_round(8'd100, 12'd1000, 12'd3000, 5);
      do_reset(3, "R11 held start");
      for (int r = 0; r < 24; r++)
         run_round(8'($urandom), 12'($urandom), 12'($urandom), 0);
      finish_run();
   end
endmodule